// File: doc/BRIEF.md
# DRAM Chip-Select Window Scanner

This block stores the address windows of four SDRAM chip selects and serves two consumers. A CPU address port is decoded against those windows at all times and reports which chip-select field the address falls into. A scan engine can also be started with a single pulse. It then walks the four windows, one per clock. Windows that a DMA master limited to 32-bit addresses can reach are packed into a small table. Each table entry holds the window index, a synthesised attribute byte, a byte base and a byte size. Logic that programs per-device DMA windows reads the table and its entry count.

Each window is a pair of 32-bit registers written through a byte-offset configuration port. The size register holds the enable flag, the chip-select field and the window size in 16 MB granules. The base register holds address bits 31:24 and the four address bits above 32.

Top module: `dram_cs_scanner`

## Requirements
- R1: A write with `cfgWe` high stores `cfgWdata` into the base register of window n at byte offset 8n, or into its size register at byte offset 8n+4; address bits 1:0 are ignored.
- R2: In the size register, bit 0 is the enable flag, bits 4:2 are the chip-select field and bits 31:24 are (granules − 1). In the base register, bits 31:24 are address bits 31:24 and bits 3:0 are address bits 35:32. An address falls in a window when its bits 35:32 equal base bits 3:0, and its bits 31:24 equal base bits 31:24 at every position where the size granule field holds a zero.
- R3: `decHit` is high when any enabled window contains `cpuAddr`. `decCs` then carries bits 4:2 of that window's size register. When several windows match, the lowest-numbered window wins. Disabled windows never match, and `decCs` is zero without a hit.
- R4: A `scanStart` sampled high while idle starts a scan that evaluates windows 0, 1, 2, 3 on the next four rising edges. `scanDone` is high for exactly one cycle, from the fourth rising edge after the starting edge to the fifth.
- R5: A window enters the table only if its enable bit is set and its base bits 3:0 are all zero.
- R6: Qualifying windows fill table slots 0 upward in ascending window order with no gaps. `tblCount` gives the number of filled slots and is final when `scanDone` is high.
- R7: In a filled slot, the 2-bit index field holds the window number. The base is base bits 31:24 followed by 24 zero bits. The 33-bit size equals (granule field + 1) × 2^24.
- R8: The 8-bit attribute of a slot is 0x0F with bit i cleared, where i is the window number. Bit 4 is set when `coherentIn` is high in the cycle that window is evaluated. Bits 7:5 are zero.
- R9: The table and count clear on the edge that starts a scan, so slots that the scan does not fill read as zero.
- R10: A `scanStart` that arrives during a scan is ignored. The scan neither restarts nor extends, and no second `scanDone` follows.
- R11: After reset all window registers, table slots and the count are zero, `scanDone` is low and no address hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 5 | Register byte offset |
| cfgWdata | input | 32 | Register write data |
| cpuAddr | input | 36 | CPU address to decode |
| decHit | output | 1 | Address falls in an enabled window |
| decCs | output | 3 | Chip-select field of the winning window |
| coherentIn | input | 1 | Sets attribute bit 4 for entries written while high |
| scanStart | input | 1 | Start a table scan |
| scanDone | output | 1 | One-cycle pulse at scan end |
| tblCount | output | 3 | Number of filled table slots |
| tblCsIdx | output | 8 | Window index per slot, 2 bits each, slot 0 in the low bits |
| tblAttr | output | 32 | Attribute per slot, 8 bits each |
| tblBase | output | 128 | Byte base per slot, 32 bits each |
| tblSize | output | 132 | Byte size per slot, 33 bits each |

## Verification
The bench covers every combination of enable flags and nonzero high base bits across the four windows, and alternates the coherency input between scans. A design that compacted wrongly would leave gaps or reorder entries. One that tested only the enable flag would admit windows above 4 GB. One that kept old slots would show stale entries after a scan that fills fewer slots. A design using the full-size granule would either wrap its size to zero or compute it one granule short. An overlap sweep places two enabled windows over the same addresses, and a wrong priority returns the higher window's chip-select field. A second start pulse in the middle of a scan would expose a restart as a late or doubled done pulse.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  // Size register layout
  localparam int EN_BIT   = 0;
  localparam int CS_LSB   = 2;
  localparam int CS_W     = 3;
  localparam int GRAN_LSB = 24;
  localparam int GRAN_W   = 8;

  // Base register layout
  localparam int HI_W     = 4;

  // Widths of decoded quantities
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 36;
  localparam int ATTR_W   = 8;
  localparam int COH_BIT  = 4;
  localparam int SIZE_W   = GRAN_W + 1 + GRAN_LSB;

  // Strobes from control to the table datapath
  typedef struct packed {
    logic clearTbl;
    logic evalWin;
  } dcsCtrlT;

endpackage

// File: rtl/dcs_regfile.sv
module dcs_regfile
  import dcs_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int REG_AW = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [REG_AW-1:0] cfgAddr,
  input  logic [REG_W-1:0]  cfgWdata,
  output logic [REG_W-1:0]  baseQ [NUM_WIN],
  output logic [REG_W-1:0]  sizeQ [NUM_WIN]
);

  logic [IDX_W-1:0] winSel;
  logic             sizeSel;

  assign winSel  = cfgAddr[REG_AW-1:3];
  assign sizeSel = cfgAddr[2];

  for (genvar g = 0; g < NUM_WIN; g++) begin : gWin
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ[g] <= '0;
        sizeQ[g] <= '0;
      end else if (cfgWe && (winSel == IDX_W'(g))) begin
        if (sizeSel) sizeQ[g] <= cfgWdata;
        else         baseQ[g] <= cfgWdata;
      end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWe && winSel == IDX_W'(g) && sizeSel) |=> (sizeQ[g] == $past(cfgWdata))) // R1
      else $error("size write lost");
  end

endmodule

// File: rtl/dcs_decoder.sv
module dcs_decoder
  import dcs_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_W-1:0]  baseQ [NUM_WIN],
  input  logic [REG_W-1:0]  sizeQ [NUM_WIN],
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              decHit,
  output logic [CS_W-1:0]   decCs
);

  logic [NUM_WIN-1:0] matchVec;
  logic [IDX_W-1:0]   decIdx;

  for (genvar g = 0; g < NUM_WIN; g++) begin : gMatch
    logic [GRAN_W-1:0] diff;
    logic              hiEq;
    assign diff = (cpuAddr[GRAN_LSB +: GRAN_W] ^ baseQ[g][GRAN_LSB +: GRAN_W])
                  & ~sizeQ[g][GRAN_LSB +: GRAN_W];
    assign hiEq = (cpuAddr[ADDR_W-1 -: HI_W] == baseQ[g][HI_W-1:0]);
    assign matchVec[g] = sizeQ[g][EN_BIT] && hiEq && (diff == '0);
  end

  always_comb begin
    decHit = 1'b0;
    decIdx = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (matchVec[w]) begin
        decHit = 1'b1;
        decIdx = IDX_W'(w);
      end
    end
  end

  always_comb begin
    decCs = '0;
    if (decHit) decCs = sizeQ[decIdx][CS_LSB +: CS_W];
  end

  AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    decHit |-> sizeQ[decIdx][EN_BIT]) // R3
    else $error("hit on disabled window");

  AST_NO_HIT_NO_CS: assert property (@(posedge clk) disable iff (!rstN)
    !decHit |-> (decCs == '0)) // R3
    else $error("cs without hit");

endmodule

// File: rtl/dcs_ctrl.sv
module dcs_ctrl
  import dcs_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             scanStart,
  output dcsCtrlT          ctrl,
  output logic [IDX_W-1:0] winIdx,
  output logic             scanDone
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_WIN - 1);

  typedef enum logic {ST_IDLE, ST_SCAN} stT;

  stT               state;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      idx      <= '0;
      scanDone <= 1'b0;
    end else begin
      scanDone <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (scanStart) begin
            state <= ST_SCAN;
            idx   <= '0;
          end
        end
        ST_SCAN: begin
          if (idx == LAST) begin
            state    <= ST_IDLE;
            scanDone <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.clearTbl = (state == ST_IDLE) && scanStart;
    ctrl.evalWin  = (state == ST_SCAN);
    winIdx        = idx;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> !scanDone) // R4
    else $error("done longer than one cycle");

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(scanDone) |-> ($past(ctrl.evalWin) && $past(winIdx) == LAST)) // R4
    else $error("done without last window");

  AST_SCAN_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.evalWin && winIdx != LAST) |=> (ctrl.evalWin && winIdx == $past(winIdx) + 1'b1)) // R10
    else $error("scan restarted or stalled");

endmodule

// File: rtl/dcs_datapath.sv
module dcs_datapath
  import dcs_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int CNT_W  = $clog2(NUM_WIN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_W-1:0]  baseQ [NUM_WIN],
  input  logic [REG_W-1:0]  sizeQ [NUM_WIN],
  input  logic              coherentIn,
  input  dcsCtrlT           ctrl,
  input  logic [IDX_W-1:0]  winIdx,
  output logic [CNT_W-1:0]  tblCount,
  output logic [IDX_W-1:0]  slotCs   [NUM_WIN],
  output logic [ATTR_W-1:0] slotAttr [NUM_WIN],
  output logic [REG_W-1:0]  slotBase [NUM_WIN],
  output logic [SIZE_W-1:0] slotSize [NUM_WIN]
);

  logic [REG_W-1:0]  curBase;
  logic [REG_W-1:0]  curSize;
  logic              qualify;
  logic [ATTR_W-1:0] attrV;
  logic [GRAN_W:0]   granCnt;
  logic [SIZE_W-1:0] sizeV;
  logic [REG_W-1:0]  baseV;

  assign curBase = baseQ[winIdx];
  assign curSize = sizeQ[winIdx];
  assign qualify = curSize[EN_BIT] && (curBase[HI_W-1:0] == '0);
  assign granCnt = {1'b0, curSize[GRAN_LSB +: GRAN_W]} + 1'b1;
  assign sizeV   = {granCnt, {GRAN_LSB{1'b0}}};
  assign baseV   = {curBase[GRAN_LSB +: GRAN_W], {GRAN_LSB{1'b0}}};

  always_comb begin
    attrV = '0;
    for (int b = 0; b < NUM_WIN; b++) attrV[b] = (b != int'(winIdx));
    attrV[COH_BIT] = coherentIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clearTbl) begin
      tblCount <= '0;
    end else if (ctrl.evalWin && qualify) begin
      tblCount <= tblCount + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN || ctrl.clearTbl) begin
        slotCs[g]   <= '0;
        slotAttr[g] <= '0;
        slotBase[g] <= '0;
        slotSize[g] <= '0;
      end else if (ctrl.evalWin && qualify && tblCount == CNT_W'(g)) begin
        slotCs[g]   <= winIdx;
        slotAttr[g] <= attrV;
        slotBase[g] <= baseV;
        slotSize[g] <= sizeV;
      end
    end

    AST_ATTR_ONECOLD: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.evalWin && qualify && tblCount == CNT_W'(g))
        |=> ($countones(slotAttr[g][NUM_WIN-1:0]) == NUM_WIN - 1)) // R8
      else $error("attribute not one-cold");
  end

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clearTbl |=> (tblCount == '0)) // R9
    else $error("count not cleared");

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.evalWin |=> (tblCount == $past(tblCount) || tblCount == $past(tblCount) + 1'b1)) // R6
    else $error("count jumped");

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.evalWin && !ctrl.clearTbl) |=> $stable(tblCount)) // R6
    else $error("count moved outside scan");

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    tblCount <= CNT_W'(NUM_WIN)) // R6
    else $error("count overflow");

endmodule

// File: rtl/dram_cs_scanner.sv
module dram_cs_scanner
  import dcs_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int CNT_W  = $clog2(NUM_WIN + 1),
  localparam int REG_AW = IDX_W + 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWe,
  input  logic [REG_AW-1:0]           cfgAddr,
  input  logic [REG_W-1:0]            cfgWdata,
  input  logic [ADDR_W-1:0]           cpuAddr,
  output logic                        decHit,
  output logic [CS_W-1:0]             decCs,
  input  logic                        coherentIn,
  input  logic                        scanStart,
  output logic                        scanDone,
  output logic [CNT_W-1:0]            tblCount,
  output logic [NUM_WIN*IDX_W-1:0]    tblCsIdx,
  output logic [NUM_WIN*ATTR_W-1:0]   tblAttr,
  output logic [NUM_WIN*REG_W-1:0]    tblBase,
  output logic [NUM_WIN*SIZE_W-1:0]   tblSize
);

  logic [REG_W-1:0]  baseQ    [NUM_WIN];
  logic [REG_W-1:0]  sizeQ    [NUM_WIN];
  logic [IDX_W-1:0]  slotCs   [NUM_WIN];
  logic [ATTR_W-1:0] slotAttr [NUM_WIN];
  logic [REG_W-1:0]  slotBase [NUM_WIN];
  logic [SIZE_W-1:0] slotSize [NUM_WIN];
  dcsCtrlT           ctrl;
  logic [IDX_W-1:0]  winIdx;

  dcs_regfile #(.NUM_WIN(NUM_WIN)) uRegs (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .baseQ(baseQ), .sizeQ(sizeQ)
  );

  dcs_decoder #(.NUM_WIN(NUM_WIN)) uDec (
    .clk(clk), .rstN(rstN), .baseQ(baseQ), .sizeQ(sizeQ),
    .cpuAddr(cpuAddr), .decHit(decHit), .decCs(decCs)
  );

  dcs_ctrl #(.NUM_WIN(NUM_WIN)) uCtrl (
    .clk(clk), .rstN(rstN), .scanStart(scanStart),
    .ctrl(ctrl), .winIdx(winIdx), .scanDone(scanDone)
  );

  dcs_datapath #(.NUM_WIN(NUM_WIN)) uDp (
    .clk(clk), .rstN(rstN), .baseQ(baseQ), .sizeQ(sizeQ),
    .coherentIn(coherentIn), .ctrl(ctrl), .winIdx(winIdx),
    .tblCount(tblCount), .slotCs(slotCs), .slotAttr(slotAttr),
    .slotBase(slotBase), .slotSize(slotSize)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : gFlat
    assign tblCsIdx[g*IDX_W  +: IDX_W]  = slotCs[g];
    assign tblAttr [g*ATTR_W +: ATTR_W] = slotAttr[g];
    assign tblBase [g*REG_W  +: REG_W]  = slotBase[g];
    assign tblSize [g*SIZE_W +: SIZE_W] = slotSize[g];
  end

endmodule

// File: tb/sim_dram_cs_scanner.sv
`timescale 1ns/1ps
module sim_dram_cs_scanner;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [4:0]    cfgAddr = '0;
  logic [31:0]   cfgWdata = '0;
  logic [35:0]   cpuAddr = '0;
  logic          decHit;
  logic [2:0]    decCs;
  logic          coherentIn = 1'b0;
  logic          scanStart = 1'b0;
  logic          scanDone;
  logic [2:0]    tblCount;
  logic [7:0]    tblCsIdx;
  logic [31:0]   tblAttr;
  logic [127:0]  tblBase;
  logic [131:0]  tblSize;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [31:0] mBase [4];
  logic [31:0] mSize [4];

  always #2 clk = ~clk;

  dram_cs_scanner u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cpuAddr(cpuAddr), .decHit(decHit), .decCs(decCs),
    .coherentIn(coherentIn), .scanStart(scanStart), .scanDone(scanDone),
    .tblCount(tblCount), .tblCsIdx(tblCsIdx), .tblAttr(tblAttr),
    .tblBase(tblBase), .tblSize(tblSize)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setWin(input int i, input logic [31:0] b, input logic [31:0] s);
    mBase[i] = b;
    mSize[i] = s;
    wr(5'(i * 8), b);
    wr(5'(i * 8 + 4), s);
  endtask

  function automatic logic [3:0] expDecode(input logic [35:0] a);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] d;
      d = (a[31:24] ^ mBase[i][31:24]) & ~mSize[i][31:24];
      if (mSize[i][0] && a[35:32] == mBase[i][3:0] && d == 8'h0)
        return {1'b1, mSize[i][4:2]};
    end
    return 4'h0;
  endfunction

  task automatic checkDecode(input logic [35:0] a, input string tag);
    logic [3:0] e;
    @(negedge clk);
    cpuAddr = a;
    #1;
    e = expDecode(a);
    check({tag, " hit"}, 64'(decHit), 64'(e[3]));
    check({tag, " cs"},  64'(decCs),  64'(e[2:0]));
  endtask

  task automatic runScan(input bit extraStart);
    @(negedge clk);
    scanStart = 1'b1;
    @(posedge clk);
    @(negedge clk);
    scanStart = 1'b0;
    for (int e = 1; e <= 6; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (extraStart && e == 1) scanStart = 1'b1;
      if (e == 2) scanStart = 1'b0;
      if (e == 3) check("R4 done low before end", 64'(scanDone), 64'd0);
      if (e == 4) check("R4 done pulse", 64'(scanDone), 64'd1);
      if (e == 5) check("R10 R4 done one cycle", 64'(scanDone), 64'd0);
      if (e == 6) check("R10 no second done", 64'(scanDone), 64'd0);
    end
  endtask

  task automatic checkTable(input bit coh);
    int k;
    logic [1:0]  eCs   [4];
    logic [7:0]  eAttr [4];
    logic [31:0] eBase [4];
    logic [32:0] eSize [4];
    for (int s = 0; s < 4; s++) begin
      eCs[s] = '0; eAttr[s] = '0; eBase[s] = '0; eSize[s] = '0;
    end
    k = 0;
    for (int i = 0; i < 4; i++) begin
      if (mSize[i][0] && mBase[i][3:0] == 4'h0) begin
        eCs[k]   = 2'(i);
        eAttr[k] = (8'h0F & ~(8'h01 << i)) | (coh ? 8'h10 : 8'h00);
        eBase[k] = {mBase[i][31:24], 24'h0};
        eSize[k] = 33'(({25'h0, mSize[i][31:24]} + 33'd1) << 24);
        k++;
      end
    end
    check("R5 R6 count", 64'(tblCount), 64'(k));
    for (int s = 0; s < 4; s++) begin
      check($sformatf("R6 R9 slot%0d index", s), 64'(tblCsIdx[s*2 +: 2]), 64'(eCs[s]));
      check($sformatf("R8 slot%0d attr", s), 64'(tblAttr[s*8 +: 8]), 64'(eAttr[s]));
      check($sformatf("R7 slot%0d base", s), 64'(tblBase[s*32 +: 32]), 64'(eBase[s]));
      check($sformatf("R7 slot%0d size", s), 64'(tblSize[s*33 +: 33]), 64'(eSize[s]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mBase[i] = '0; mSize[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R11 reset count", 64'(tblCount), 64'd0);
    check("R11 reset done", 64'(scanDone), 64'd0);
    check("R11 reset idx", 64'(tblCsIdx), 64'd0);
    check("R11 reset attr", 64'(tblAttr), 64'd0);
    check("R11 reset base", 64'(tblBase[63:0]) | 64'(tblBase[127:64]), 64'd0);
    check("R11 reset size", 64'(tblSize[65:0] != '0) | 64'(tblSize[131:66] != '0), 64'd0);
    check("R11 reset hit", 64'(decHit), 64'd0);

    // Exhaustive enable / high-bit sweep
    for (int combo = 0; combo < 256; combo++) begin
      bit coh;
      coh = ^combo[7:0];
      for (int i = 0; i < 4; i++) begin
        logic [31:0] b, s;
        b = {8'(1 << i), 20'h0, (combo[4+i] ? 4'(i + 1) : 4'h0)};
        s = {8'((1 << i) - 1), 19'h0, 3'((i + 2) & 7), 1'b0, combo[i]};
        setWin(i, b, s);
      end
      @(negedge clk);
      coherentIn = coh;
      runScan(combo % 7 == 3);
      checkTable(coh);
      for (int i = 0; i < 4; i++) begin
        logic [35:0] a;
        a = {mBase[i][3:0], 8'(1 << i), 24'h5A5A5A};
        checkDecode(a, "R1 R2 R3 window bottom");
        a = {mBase[i][3:0], 8'((1 << i) + (1 << i) - 1), 24'hFFFFFF};
        checkDecode(a, "R2 R3 window top");
      end
    end

    // Overlap and priority sweep
    setWin(0, 32'h4000_0000, 32'h3F00_0001 | (32'd1 << 2));
    setWin(1, 32'h4000_0000, 32'h0F00_0001 | (32'd6 << 2));
    setWin(2, 32'h8000_0001, 32'h7F00_0001 | (32'd5 << 2));
    setWin(3, 32'h0000_0000, 32'hFF00_0000 | (32'd7 << 2));
    for (int hi = 0; hi < 2; hi++) begin
      for (int a = 0; a < 256; a++) begin
        checkDecode({4'(hi), 8'(a), 24'h000001}, "R3 overlap priority");
      end
    end

    // Address bits 1:0 ignored on write
    wr(5'd3 * 5'd8 + 5'd7, 32'hFF00_0001 | (32'd3 << 2));
    mSize[3] = 32'hFF00_0001 | (32'd3 << 2);
    checkDecode(36'h0_0100_0000, "R1 low offset bits ignored");

    // Full-size window in the table
    @(negedge clk);
    coherentIn = 1'b1;
    runScan(1'b0);
    checkTable(1'b1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule